// File: doc/BRIEF.md
# Root Port Link-Up Retry Controller

This block brings up one root port of a serial link controller. When a start pulse arrives it turns on the port's reference clock, the override enable and, in variants that have one, the clock request enable. It forces the presence mapping code to "endpoint present" and holds the port in reset for a fixed number of millisecond ticks. It then releases the reset and polls in two phases. The first phase waits for data-link-up and the second for link-active. Each phase has its own bounded number of samples. The samples are spaced a fixed number of ticks apart, and the first one is taken in the cycle after the phase is entered.

If the first phase times out, the second phase is skipped. Any timed-out attempt is followed by a fresh reset pulse and a new attempt. After the last permitted attempt fails, the controller asserts the port reset. One cycle later it removes the reference clock and reports the port as failed. The link training logic is outside this block. Only its two status bits and a free-running millisecond tick enter the block.

Top module: `link_retry_ctrl`

## Requirements
- R1: After reset, port_rst_no is 0, refclk_en_o, clkreq_en_o and override_en_o are 0, prsnt_map_o is 4'hF (absent code), and link_good_o and link_fail_o are 0.
- R2: A start_i accepted in idle or after a result sets refclk_en_o and override_en_o to 1, sets clkreq_en_o to the CLKREQ_EN parameter, sets prsnt_map_o to 4'hE (present code), and clears both results, all in the next cycle.
- R3: Each attempt begins with port_rst_no held at 0 until exactly RST_MS ms_tick_i pulses have been seen, and port_rst_no rises in the cycle after the last of those pulses.
- R4: In phase one, dl_up_i is sampled in the first cycle after reset release and then once after every POLL_MS ticks, for at most POLL_MAX samples. After (POLL_MAX-1)*POLL_MS ticks with no hit, the attempt ends with port_rst_no dropping, and phase two is skipped.
- R5: Phase two starts on a phase-one hit and samples link_active_i on the same schedule and bound. A hit raises link_good_o one cycle later and leaves port_rst_no at 1. A phase-two timeout ends the attempt the same way a phase-one timeout does.
- R6: At most ATTEMPTS attempts (reset pulses followed by polling) are made per sequence, and the attempt and poll counts restart from zero at every accepted start.
- R7: When the final attempt fails, port_rst_no drops while refclk_en_o is still 1. In the next cycle refclk_en_o goes to 0 and link_fail_o goes to 1.
- R8: A start_i that arrives while a sequence is in progress is ignored. It has no effect on timing, attempt count or result.
- R9: link_good_o and link_fail_o are never both 1. Once set, a result and the port controls hold steady until the next accepted start.

Parameters: RST_MS (2), POLL_MS (2), POLL_MAX (200), ATTEMPTS (3), CLKREQ_EN (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a bring-up sequence |
| dl_up_i | input | 1 | Data link up status from the port |
| link_active_i | input | 1 | Link active status from the port |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| port_rst_no | output | 1 | Port reset, active low |
| refclk_en_o | output | 1 | Reference clock enable |
| clkreq_en_o | output | 1 | Clock request enable |
| override_en_o | output | 1 | Port control override enable |
| prsnt_map_o | output | 4 | Presence mapping code (4'hE present, 4'hF absent) |
| link_good_o | output | 1 | Link came up |
| link_fail_o | output | 1 | All attempts failed, port powered down |

## Verification
The poll phase, the tick timer and the attempt count are not visible directly. The bench infers them by counting ms_tick_i pulses while port_rst_no is high and while it is low in each attempt, and by counting the rising edges of port_rst_no. If the interval timer is off by one, the per-attempt tick count moves away from its exact expected value at the first timeout, about 400 ticks into the sequence. A wrong phase state or a wrong attempt limit shows up as an extra or a missing reset pulse, or as a result that flips. A misordered shutdown shows up in the single cycle between the reset being asserted and the reference clock being removed.

// File: rtl/lr_pkg.sv
package lr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_POLL_DL,
    ST_POLL_LA,
    ST_KILL,
    ST_OK,
    ST_FAIL
  } lr_state_e;

  localparam logic [3:0] MAP_PRESENT = 4'hE;
  localparam logic [3:0] MAP_ABSENT  = 4'hF;
endpackage

// File: rtl/lr_tick_timer.sv
module lr_tick_timer #(
  parameter int TW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == limit_i - TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else if (tick_i)   cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/lr_bound_ctr.sv
module lr_bound_ctr #(
  parameter int LIMIT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  assign last_o = (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + W'(1);
  end

  // R4 / R6: counter never passes its bound
  p_ctr_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < W'(LIMIT));
endmodule

// File: rtl/link_retry_ctrl.sv
module link_retry_ctrl
  import lr_pkg::*;
#(
  parameter int   RST_MS    = 2,
  parameter int   POLL_MS   = 2,
  parameter int   POLL_MAX  = 200,
  parameter int   ATTEMPTS  = 3,
  parameter logic CLKREQ_EN = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       dl_up_i,
  input  logic       link_active_i,
  input  logic       ms_tick_i,
  output logic       port_rst_no,
  output logic       refclk_en_o,
  output logic       clkreq_en_o,
  output logic       override_en_o,
  output logic [3:0] prsnt_map_o,
  output logic       link_good_o,
  output logic       link_fail_o
);
  localparam int MAXI = (RST_MS > POLL_MS) ? RST_MS : POLL_MS;
  localparam int TW   = $clog2(MAXI + 1);

  lr_state_e state_q, state_d;
  logic      pend_q;
  logic      refclk_q, clkreq_q, ovr_q;
  logic [3:0] map_q;

  logic start_ok, in_poll, sample, status, hit, miss_last;
  logic expire, poll_last, att_last, leave;
  logic [TW-1:0] limit;

  assign start_ok  = start_i && (state_q inside {ST_IDLE, ST_OK, ST_FAIL});
  assign in_poll   = (state_q == ST_POLL_DL) || (state_q == ST_POLL_LA);
  assign sample    = in_poll && pend_q;
  assign status    = (state_q == ST_POLL_DL) ? dl_up_i : link_active_i;
  assign hit       = sample && status;
  assign miss_last = sample && !status && poll_last;
  assign limit     = (state_q == ST_RST) ? TW'(RST_MS) : TW'(POLL_MS);
  assign leave     = (state_d != state_q);

  lr_tick_timer #(.TW(TW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (leave),
    .tick_i  (ms_tick_i),
    .limit_i (limit),
    .expire_o(expire)
  );

  lr_bound_ctr #(.LIMIT(POLL_MAX)) u_poll_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (leave),
    .inc_i (sample && !status && !poll_last),
    .last_o(poll_last)
  );

  lr_bound_ctr #(.LIMIT(ATTEMPTS)) u_att_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start_ok),
    .inc_i (miss_last && !att_last),
    .last_o(att_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_OK, ST_FAIL: if (start_ok) state_d = ST_RST;
      ST_RST:     if (expire) state_d = ST_POLL_DL;
      ST_POLL_DL: begin
        if (hit)            state_d = ST_POLL_LA;
        else if (miss_last) state_d = att_last ? ST_KILL : ST_RST;
      end
      ST_POLL_LA: begin
        if (hit)            state_d = ST_OK;
        else if (miss_last) state_d = att_last ? ST_KILL : ST_RST;
      end
      ST_KILL:    state_d = ST_FAIL;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pend_q   <= 1'b0;
      refclk_q <= 1'b0;
      clkreq_q <= 1'b0;
      ovr_q    <= 1'b0;
      map_q    <= MAP_ABSENT;
    end else begin
      state_q <= state_d;
      // first sample right after phase entry, then one per interval
      pend_q  <= leave | expire | (pend_q & ~sample);
      if (start_ok) begin
        refclk_q <= 1'b1;
        clkreq_q <= CLKREQ_EN;
        ovr_q    <= 1'b1;
        map_q    <= MAP_PRESENT;
      end else if (state_q == ST_KILL) begin
        refclk_q <= 1'b0;
      end
    end
  end

  assign port_rst_no   = state_q inside {ST_POLL_DL, ST_POLL_LA, ST_OK};
  assign refclk_en_o   = refclk_q;
  assign clkreq_en_o   = clkreq_q;
  assign override_en_o = ovr_q;
  assign prsnt_map_o   = map_q;
  assign link_good_o   = (state_q == ST_OK);
  assign link_fail_o   = (state_q == ST_FAIL);

  p_release_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(port_rst_no) |-> $past(ms_tick_i));

  p_good_needs_active_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_good_o) |-> $past(link_active_i) && port_rst_no);

  p_fail_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(refclk_en_o) |-> !port_rst_no && $past(!port_rst_no) && link_fail_o);

  p_result_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_good_o && link_fail_o));

  p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_good_o || link_fail_o) && !start_i |=>
      $stable({link_good_o, link_fail_o, refclk_en_o, port_rst_no}));

  p_map_present_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refclk_en_o |-> prsnt_map_o == MAP_PRESENT && override_en_o);
endmodule

// File: tb/tb_link_retry_ctrl.sv
module tb_link_retry_ctrl;
  localparam int RST_MS = 2, POLL_MS = 2, POLL_MAX = 200, ATT = 3, TP = 4;
  localparam int TO = (POLL_MAX - 1) * POLL_MS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, dl_up_i = 1'b0, link_active_i = 1'b0, ms_tick_i = 1'b0;
  logic port_rst_no, refclk_en_o, clkreq_en_o, override_en_o, link_good_o, link_fail_o;
  logic [3:0] prsnt_map_o;

  always #5 clk = ~clk;

  link_retry_ctrl #(.RST_MS(RST_MS), .POLL_MS(POLL_MS), .POLL_MAX(POLL_MAX),
                    .ATTEMPTS(ATT), .CLKREQ_EN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .dl_up_i(dl_up_i),
    .link_active_i(link_active_i), .ms_tick_i(ms_tick_i), .port_rst_no(port_rst_no),
    .refclk_en_o(refclk_en_o), .clkreq_en_o(clkreq_en_o), .override_en_o(override_en_o),
    .prsnt_map_o(prsnt_map_o), .link_good_o(link_good_o), .link_fail_o(link_fail_o));

  int n_chk = 0, n_fail = 0;
  int cfg_dl[ATT];
  bit cfg_la[ATT];
  int att_idx = 0, hi_ticks = 0, lo_ticks = 0, good_ticks = -1, cyc = 0;
  int att_hi[ATT], att_lo[ATT];
  bit port_prev = 1'b0, tick_prev = 1'b0, kill_chk = 1'b0;
  int start_req = 0, ign_mode = 0;
  bit ign_done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ceilp(input int d);
    return ((d + POLL_MS - 1) / POLL_MS) * POLL_MS;
  endfunction

  // monitor and stimulus, all on the falling edge
  always @(negedge clk) begin
    if (tick_prev) begin
      if (port_prev) hi_ticks++; else lo_ticks++;
    end
    if (port_rst_no && !port_prev) begin
      if (att_idx < ATT) att_lo[att_idx] = lo_ticks;
      att_idx++;
      hi_ticks = 0;
    end
    if (!port_rst_no && port_prev) begin
      if (att_idx >= 1 && att_idx <= ATT) att_hi[att_idx-1] = hi_ticks;
      lo_ticks = 0;
      if (att_idx == ATT && !link_good_o) begin
        chk(refclk_en_o == 1'b1 && !link_fail_o, "R7 refclk on when reset asserts",
            refclk_en_o, 1);
        kill_chk = 1'b1;
      end
    end else if (kill_chk) begin
      kill_chk = 1'b0;
      chk(refclk_en_o == 1'b0 && link_fail_o == 1'b1, "R7 refclk off and fail next cycle",
          {refclk_en_o, link_fail_o}, 1);
    end
    if (link_good_o && good_ticks < 0) good_ticks = hi_ticks;

    if (port_rst_no && att_idx >= 1 && att_idx <= ATT) begin
      dl_up_i       = (cfg_dl[att_idx-1] >= 0) && (hi_ticks >= cfg_dl[att_idx-1]);
      link_active_i = cfg_la[att_idx-1];
    end else begin
      dl_up_i = 1'b0;
      link_active_i = 1'b0;
    end

    cyc++;
    if (start_req != 0) begin
      start_i = 1'b1; ms_tick_i = 1'b0; start_req = 0;
      lo_ticks = 0; hi_ticks = 0; att_idx = 0; good_ticks = -1; ign_done = 1'b0;
    end else if (!ign_done && ign_mode == 1 && port_rst_no && att_idx == 1 && hi_ticks == 20) begin
      start_i = 1'b1; ms_tick_i = 1'b0; ign_done = 1'b1;
    end else if (!ign_done && ign_mode == 2 && !port_rst_no && att_idx == 0 && lo_ticks == 1) begin
      start_i = 1'b1; ms_tick_i = 1'b0; ign_done = 1'b1;
    end else begin
      start_i = 1'b0;
      ms_tick_i = (cyc % TP == 0);
    end
    tick_prev = ms_tick_i;
    port_prev = port_rst_no;
  end

  task automatic run_seq(input string tag);
    int exp_att = 0, exp_good = 0, exp_gt = 0;
    int exp_hi[ATT];
    for (int a = 0; a < ATT; a++) begin
      exp_att++;
      if (cfg_dl[a] < 0) exp_hi[a] = TO;
      else if (!cfg_la[a]) exp_hi[a] = ceilp(cfg_dl[a]) + TO;
      else begin exp_good = 1; exp_gt = ceilp(cfg_dl[a]); break; end
    end
    @(posedge clk);
    start_req = 1;
    @(negedge clk);
    @(negedge clk);
    chk(refclk_en_o && override_en_o && clkreq_en_o, "R2 clock controls set", 
        {refclk_en_o, override_en_o, clkreq_en_o}, 7);
    chk(prsnt_map_o == 4'hE, "R2 present code", prsnt_map_o, 14);
    chk(!link_good_o && !link_fail_o, "R9 results cleared by start", {link_good_o, link_fail_o}, 0);
    while (!(link_good_o || link_fail_o)) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(att_idx == exp_att, "R6 attempt count", att_idx, exp_att);
    chk(link_good_o == exp_good, "R5 result good", link_good_o, exp_good);
    chk(link_fail_o == !exp_good, "R7 result fail", link_fail_o, !exp_good);
    for (int a = 0; a < exp_att; a++) begin
      chk(att_lo[a] == RST_MS, "R3 reset pulse ticks", att_lo[a], RST_MS);
      if (!(exp_good && a == exp_att - 1))
        chk(att_hi[a] == exp_hi[a], "R4 ticks polled before retry", att_hi[a], exp_hi[a]);
    end
    if (exp_good)
      chk(good_ticks == exp_gt && port_rst_no, "R5 good after phase two hit", good_ticks, exp_gt);
    if (tag.len() == 0) $display("unnamed sequence");
  endtask

  task automatic set_cfg(input int d0, input bit l0, input int d1, input bit l1,
                         input int d2, input bit l2);
    cfg_dl[0] = d0; cfg_la[0] = l0;
    cfg_dl[1] = d1; cfg_la[1] = l1;
    cfg_dl[2] = d2; cfg_la[2] = l2;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    set_cfg(-1, 0, -1, 0, -1, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(port_rst_no == 0 && !refclk_en_o && !clkreq_en_o && !override_en_o, "R1 controls idle",
        {port_rst_no, refclk_en_o, clkreq_en_o, override_en_o}, 0);
    chk(prsnt_map_o == 4'hF && !link_good_o && !link_fail_o, "R1 absent code and no result",
        prsnt_map_o, 15);

    set_cfg(0, 1, -1, 0, -1, 0);   run_seq("R5 immediate");
    set_cfg(-1, 0, -1, 0, -1, 0);  run_seq("R4 phase one timeouts");
    set_cfg(-1, 0, 0, 1, -1, 0);   run_seq("R6 restart after fail");
    set_cfg(10, 0, -1, 0, -1, 0);  run_seq("R5 phase two timeout");
    set_cfg(7, 1, -1, 0, -1, 0);   run_seq("R4 odd delay");
    set_cfg(-1, 0, 5, 0, 3, 1);    run_seq("R6 third attempt");
    ign_mode = 1;
    set_cfg(-1, 0, -1, 0, -1, 0);  run_seq("R8 start during poll");
    ign_mode = 2;
    set_cfg(0, 1, -1, 0, -1, 0);   run_seq("R8 start during reset pulse");
    ign_mode = 0;

    for (int s = 0; s < 6; s++) begin
      for (int a = 0; a < ATT; a++) begin
        int r;
        r = $urandom % 4;
        cfg_dl[a] = (r == 0) ? -1 : int'($urandom % 31);
        cfg_la[a] = (r >= 2);
      end
      run_seq("random");
    end

    // R9 hold: result steady with no start
    begin
      logic g0, f0, p0;
      g0 = link_good_o; f0 = link_fail_o; p0 = port_rst_no;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (link_good_o != g0 || link_fail_o != f0 || port_rst_no != p0) begin
          chk(0, "R9 result hold", {link_good_o, link_fail_o}, {g0, f0});
          break;
        end
      end
      chk(link_good_o == g0 && link_fail_o == f0, "R9 result hold end", link_good_o, g0);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule